// File: doc/BRIEF.md
# SPI Transmit Queue Controller

This block queues outgoing words for an SPI peripheral. Each word carries the data and the per-transfer command. A host or DMA engine writes words through a push port, and the serial shifter removes them one at a time. The block keeps a count of valid words and a next-word pointer that both sides can read. It also raises three flags:

- a fill request that invites more pushes;
- a transfer-complete flag;
- an underflow flag for the case where an external master clocks a slave transfer while nothing is queued.

The shifter is not part of the block. Three strobes stand for it: one takes the head word, one marks the end of a transfer, and one marks a master-started transfer in slave mode. A single-cycle flush empties the queue. The fill flag can be routed to a DMA request or to an interrupt. The other two flags each have a gated interrupt output.

Top module: `spi_txq_ctrl`

## Requirements
- R1: During and right after reset: entry count 0, next pointer 0, fill flag 1, complete flag 0, underflow flag 0.
- R2: A push while the queue holds fewer than DEPTH (4) words raises the count by one on the next edge. A push while full is dropped: count, stored words and flags are unchanged, and no error indication exists.
- R3: A load strobe while at least one word is queued lowers the count by one and advances the next pointer by one, modulo DEPTH. A load strobe on an empty queue changes nothing.
- R4: `sh_data` shows the oldest queued word, so words leave in push order. `sh_valid` is 1 exactly when the count is nonzero.
- R5: A push and a load in the same cycle, with the queue neither full nor empty, leave the count unchanged and advance the pointer.
- R6: After any edge that leaves the count below DEPTH without a fill-clear request in that cycle, the fill flag reads 1.
- R7: The fill flag clears on the edge after a cycle in which either of these holds: the queue is full and `dma_push_done` is 1, or `flag_clr[0]` is 1. While the queue stays full, the cleared flag stays 0.
- R8: A flush sets the count, the next pointer and the write pointer to zero in one edge. A flush takes priority over a push or load in the same cycle.
- R9: `sh_eot` sets the complete flag. `flag_clr[1]` written as 1 clears it, and a set in the same cycle wins.
- R10: `slv_start` sets the underflow flag only when `slave_mode` is 1 and the queue is empty. `flag_clr[2]` clears it, and a set in the same cycle wins.
- R11: Request outputs:
  - `fill_dma_req` = fill flag AND `fill_req_en` AND `fill_to_dma`
  - `fill_irq` = fill flag AND `fill_req_en` AND NOT `fill_to_dma`
  - `done_irq` = complete flag AND `done_irq_en`
  - `uf_irq` = underflow flag AND `uf_irq_en`
- R12: `txq_full` is 1 exactly when the count equals DEPTH. `txq_empty` is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push-register write strobe |
| push_data | input | DATA_W | Command and data word to queue |
| dma_push_done | input | 1 | DMA reports its push write finished |
| flush_req | input | 1 | Clear-queue control bit written as 1 |
| flag_clr | input | 3 | Write-1-to-clear: bit0 fill, bit1 complete, bit2 underflow |
| slave_mode | input | 1 | Peripheral is in slave mode |
| sh_load | input | 1 | Shifter takes the head word |
| sh_eot | input | 1 | Shifter finished a transfer |
| slv_start | input | 1 | External master started a transfer |
| fill_req_en | input | 1 | Enable for the fill request |
| fill_to_dma | input | 1 | Route the fill request to DMA (1) or interrupt (0) |
| done_irq_en | input | 1 | Complete-interrupt enable |
| uf_irq_en | input | 1 | Underflow-interrupt enable |
| sh_data | output | DATA_W | Head word for the shifter |
| sh_valid | output | 1 | A word is queued |
| entry_count | output | CNT_W | Valid entries, 0 to DEPTH |
| next_ptr | output | PTR_W | Index of the next word to transmit |
| txq_full | output | 1 | Count equals DEPTH |
| txq_empty | output | 1 | Count is zero |
| fill_flag | output | 1 | Fill-request flag |
| done_flag | output | 1 | Transfer-complete flag |
| uf_flag | output | 1 | Underflow flag |
| fill_dma_req | output | 1 | Fill request to DMA |
| fill_irq | output | 1 | Fill request as interrupt |
| done_irq | output | 1 | Complete interrupt |
| uf_irq | output | 1 | Underflow interrupt |

## Verification
The hardest state to reach is the full queue with a cleared fill flag. It needs the queue filled exactly to DEPTH and then a DMA completion in that full cycle, and it ends the moment a load drains one word. A directed sequence pushes five words so the last one is dropped, asserts the DMA completion, and holds the queue full before draining. A long pseudo-random sweep then switches between push-heavy, load-heavy and balanced phases. In the push-heavy phase, full-queue pushes and DMA completions coincide often, and every output is compared against an arithmetic model on every cycle.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

   localparam int NUM_FLAGS = 3;
   localparam int FLG_FILL  = 0;
   localparam int FLG_TCF   = 1;
   localparam int FLG_UF    = 2;

   typedef enum logic [1:0] {
      FILL_ROUTE_PIN = 2'd0,
      FILL_ROUTE_DMA = 2'd1,
      FILL_ROUTE_IRQ = 2'd2
   } fill_route_e;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == PTR_W'(e)) begin
            word_q <= wr_data;
         end
      end
      assign slot[e] = word_q;
   end

   assign rd_data = slot[rd_idx];

endmodule

// File: rtl/txq_ptr_ctr.sv
module txq_ptr_ctr #(
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             load_req,
   input  logic             flush,
   output logic             push_ok,
   output logic             load_ok,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count_q,
   output logic             full,
   output logic             empty,
   output logic             full_d
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
   localparam logic [PTR_W-1:0] ONE_P    = PTR_W'(1);

   logic [CNT_W-1:0] count_d;

   assign full    = (count_q == FULL_CNT);
   assign empty   = (count_q == '0);
   assign push_ok = push_req & ~full & ~flush;
   assign load_ok = load_req & ~empty & ~flush;

   always_comb begin
      count_d = count_q;
      if (flush) begin
         count_d = '0;
      end else begin
         unique case ({push_ok, load_ok})
            2'b10:   count_d = count_q + ONE_C;
            2'b01:   count_d = count_q - ONE_C;
            default: count_d = count_q;
         endcase
      end
   end

   assign full_d = (count_d == FULL_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
      end else if (flush) begin
         count_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
      end else begin
         count_q <= count_d;
         if (push_ok) wr_ptr <= wr_ptr + ONE_P;
         if (load_ok) rd_ptr <= rd_ptr + ONE_P;
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);

   a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !flush) |=> $stable(wr_ptr));

   a_r3_load_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !empty && !flush) |=> (rd_ptr == $past(rd_ptr) + ONE_P));

   a_r3_empty_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && empty && !flush) |=> $stable(rd_ptr));

   a_r5_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && load_ok) |=> $stable(count_q));

   a_r8_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0 && rd_ptr == '0 && wr_ptr == '0));

endmodule

// File: rtl/txq_flags.sv
module txq_flags
   import spi_txq_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 full_q,
   input  logic                 empty_q,
   input  logic                 full_d,
   input  logic                 dma_push_done,
   input  logic [NUM_FLAGS-1:0] clr,
   input  logic                 eot,
   input  logic                 slave_mode,
   input  logic                 slv_start,
   output logic                 fill_q,
   output logic                 tcf_q,
   output logic                 uf_q
);

   localparam int NUM_EV = 2;

   logic              fill_clr;
   logic [NUM_EV-1:0] ev_set;
   logic [NUM_EV-1:0] ev_clr;
   logic [NUM_EV-1:0] ev_q;

   assign fill_clr = (full_q & dma_push_done) | clr[FLG_FILL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= 1'b1;
      end else if (fill_clr) begin
         fill_q <= 1'b0;
      end else if (!full_d) begin
         fill_q <= 1'b1;
      end
   end

   assign ev_set = {slave_mode & slv_start & empty_q, eot};
   assign ev_clr = {clr[FLG_UF], clr[FLG_TCF]};

   for (genvar k = 0; k < NUM_EV; k++) begin : g_event
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (ev_set[k]) begin
            flag_q <= 1'b1;
         end else if (ev_clr[k]) begin
            flag_q <= 1'b0;
         end
      end
      assign ev_q[k] = flag_q;
   end

   assign tcf_q = ev_q[0];
   assign uf_q  = ev_q[1];

   a_r7_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && dma_push_done) |=> !fill_q);

   a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr[FLG_FILL] |=> !fill_q);

   a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      eot |=> tcf_q);

   a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[FLG_TCF] && !eot) |=> !tcf_q);

   a_r10_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && slv_start && empty_q) |=> uf_q);

   a_r10_uf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!uf_q && !(slave_mode && slv_start && empty_q)) |=> !uf_q);

endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl
   import spi_txq_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          DEPTH      = 4,
   parameter fill_route_e FILL_ROUTE = FILL_ROUTE_PIN,
   localparam int         PTR_W      = $clog2(DEPTH),
   localparam int         CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_valid,
   input  logic [DATA_W-1:0]    push_data,
   input  logic                 dma_push_done,
   input  logic                 flush_req,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   input  logic                 slave_mode,
   input  logic                 sh_load,
   input  logic                 sh_eot,
   input  logic                 slv_start,
   input  logic                 fill_req_en,
   input  logic                 fill_to_dma,
   input  logic                 done_irq_en,
   input  logic                 uf_irq_en,
   output logic [DATA_W-1:0]    sh_data,
   output logic                 sh_valid,
   output logic [CNT_W-1:0]     entry_count,
   output logic [PTR_W-1:0]     next_ptr,
   output logic                 txq_full,
   output logic                 txq_empty,
   output logic                 fill_flag,
   output logic                 done_flag,
   output logic                 uf_flag,
   output logic                 fill_dma_req,
   output logic                 fill_irq,
   output logic                 done_irq,
   output logic                 uf_irq
);

   if (DATA_W < 1) begin : g_bad_width
      $error("spi_txq_ctrl: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_txq_ctrl: DEPTH must be a power of two, at least 2");
   end

   logic             push_ok;
   logic             load_ok;
   logic             full_d;
   logic [PTR_W-1:0] wr_ptr;

   txq_ptr_ctr #(.DEPTH(DEPTH)) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_valid),
      .load_req (sh_load),
      .flush    (flush_req),
      .push_ok  (push_ok),
      .load_ok  (load_ok),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (next_ptr),
      .count_q  (entry_count),
      .full     (txq_full),
      .empty    (txq_empty),
      .full_d   (full_d)
   );

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk     (clk),
      .wr_en   (push_ok),
      .wr_idx  (wr_ptr),
      .wr_data (push_data),
      .rd_idx  (next_ptr),
      .rd_data (sh_data)
   );

   txq_flags i_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .full_q        (txq_full),
      .empty_q       (txq_empty),
      .full_d        (full_d),
      .dma_push_done (dma_push_done),
      .clr           (flag_clr),
      .eot           (sh_eot),
      .slave_mode    (slave_mode),
      .slv_start     (slv_start),
      .fill_q        (fill_flag),
      .tcf_q         (done_flag),
      .uf_q          (uf_flag)
   );

   assign sh_valid = ~txq_empty;
   assign done_irq = done_flag & done_irq_en;
   assign uf_irq   = uf_flag & uf_irq_en;

   if (FILL_ROUTE == FILL_ROUTE_DMA) begin : g_fill_dma
      assign fill_dma_req = fill_flag & fill_req_en;
      assign fill_irq     = 1'b0;
   end else if (FILL_ROUTE == FILL_ROUTE_IRQ) begin : g_fill_irq
      assign fill_dma_req = 1'b0;
      assign fill_irq     = fill_flag & fill_req_en;
   end else begin : g_fill_pin
      assign fill_dma_req = fill_flag & fill_req_en & fill_to_dma;
      assign fill_irq     = fill_flag & fill_req_en & ~fill_to_dma;
   end

   a_r6_fill_when_room: assert property (@(posedge clk) disable iff (!rst_n)
      !((txq_full && dma_push_done) || flag_clr[FLG_FILL]) |=> (txq_full || fill_flag));

   a_r11_done_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> done_flag);

   a_r12_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({txq_full, txq_empty}));

   a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_valid && !sh_load && !flush_req) |=> $stable(sh_data));

endmodule

// File: tb/test_spi_txq_ctrl.sv
module test_spi_txq_ctrl;

   localparam int DW  = 32;
   localparam int DEP = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          push_valid;
   logic [DW-1:0] push_data;
   logic          dma_push_done;
   logic          flush_req;
   logic [2:0]    flag_clr;
   logic          slave_mode;
   logic          sh_load;
   logic          sh_eot;
   logic          slv_start;
   logic          fill_req_en;
   logic          fill_to_dma;
   logic          done_irq_en;
   logic          uf_irq_en;
   logic [DW-1:0] sh_data;
   logic          sh_valid;
   logic [2:0]    entry_count;
   logic [1:0]    next_ptr;
   logic          txq_full, txq_empty;
   logic          fill_flag, done_flag, uf_flag;
   logic          fill_dma_req, fill_irq, done_irq, uf_irq;

   spi_txq_ctrl i_spi_txq_ctrl (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .dma_push_done(dma_push_done), .flush_req(flush_req), .flag_clr(flag_clr),
      .slave_mode(slave_mode), .sh_load(sh_load), .sh_eot(sh_eot),
      .slv_start(slv_start), .fill_req_en(fill_req_en), .fill_to_dma(fill_to_dma),
      .done_irq_en(done_irq_en), .uf_irq_en(uf_irq_en), .sh_data(sh_data),
      .sh_valid(sh_valid), .entry_count(entry_count), .next_ptr(next_ptr),
      .txq_full(txq_full), .txq_empty(txq_empty), .fill_flag(fill_flag),
      .done_flag(done_flag), .uf_flag(uf_flag), .fill_dma_req(fill_dma_req),
      .fill_irq(fill_irq), .done_irq(done_irq), .uf_irq(uf_irq)
   );

   always #10 clk = ~clk;

   int          n_vec = 0;
   int          n_bad = 0;
   int          m_cnt, m_wp, m_rp;
   logic [31:0] m_mem [DEP];
   bit          m_fill, m_tcf, m_uf;
   logic [31:0] rng = 32'h1234_5678;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(string ctx);
      chk("R2",  {ctx, " count"},  32'(entry_count), 32'(m_cnt));
      chk("R3",  {ctx, " ptr"},    32'(next_ptr), 32'(m_rp));
      chk("R12", {ctx, " full"},   32'(txq_full), 32'(m_cnt == DEP));
      chk("R12", {ctx, " empty"},  32'(txq_empty), 32'(m_cnt == 0));
      chk("R6",  {ctx, " fill"},   32'(fill_flag), 32'(m_fill));
      chk("R9",  {ctx, " done"},   32'(done_flag), 32'(m_tcf));
      chk("R10", {ctx, " uf"},     32'(uf_flag), 32'(m_uf));
      chk("R4",  {ctx, " valid"},  32'(sh_valid), 32'(m_cnt > 0));
      if (m_cnt > 0) chk("R4", {ctx, " head"}, sh_data, m_mem[m_rp]);
      chk("R11", {ctx, " fdma"},   32'(fill_dma_req), 32'(m_fill & fill_req_en & fill_to_dma));
      chk("R11", {ctx, " firq"},   32'(fill_irq), 32'(m_fill & fill_req_en & ~fill_to_dma));
      chk("R11", {ctx, " dirq"},   32'(done_irq), 32'(m_tcf & done_irq_en));
      chk("R11", {ctx, " uirq"},   32'(uf_irq), 32'(m_uf & uf_irq_en));
   endtask

   task automatic model_step();
      bit push_ok, load_ok, fclr;
      int old_cnt;
      if (!rst_n) begin
         m_cnt = 0; m_wp = 0; m_rp = 0;
         m_fill = 1; m_tcf = 0; m_uf = 0;
         return;
      end
      old_cnt = m_cnt;
      push_ok = push_valid && old_cnt < DEP && !flush_req;
      load_ok = sh_load && old_cnt > 0 && !flush_req;
      fclr    = (old_cnt == DEP && dma_push_done) || flag_clr[0];
      if (flush_req) begin
         m_cnt = 0; m_wp = 0; m_rp = 0;
      end else begin
         if (push_ok) begin
            m_mem[m_wp] = push_data;
            m_wp = (m_wp + 1) % DEP;
         end
         if (load_ok) m_rp = (m_rp + 1) % DEP;
         m_cnt = old_cnt + int'(push_ok) - int'(load_ok);
      end
      if (fclr) m_fill = 0;
      else if (m_cnt < DEP) m_fill = 1;
      if (sh_eot) m_tcf = 1;
      else if (flag_clr[1]) m_tcf = 0;
      if (slave_mode && slv_start && old_cnt == 0) m_uf = 1;
      else if (flag_clr[2]) m_uf = 0;
   endtask

   task automatic tick(string ctx);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all(ctx);
   endtask

   task automatic idle();
      push_valid = 0; push_data = '0; dma_push_done = 0; flush_req = 0;
      flag_clr = '0; sh_load = 0; sh_eot = 0; slv_start = 0;
   endtask

   function automatic logic [31:0] next_rng(logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 0;
      idle();
      slave_mode = 1; fill_req_en = 1; fill_to_dma = 1;
      done_irq_en = 1; uf_irq_en = 1;
      repeat (3) @(negedge clk);
      model_step();
      chk("R1", "reset count", 32'(entry_count), 0);
      chk("R1", "reset ptr",   32'(next_ptr), 0);
      chk("R1", "reset fill",  32'(fill_flag), 1);
      chk("R1", "reset done",  32'(done_flag), 0);
      chk("R1", "reset uf",    32'(uf_flag), 0);
      rst_n = 1;
      tick("R1 after release");

      // R2: fill to DEPTH, the fifth push is dropped
      for (int i = 0; i < 5; i++) begin
         push_valid = 1; push_data = 32'hA000_0000 + 32'(i);
         tick("R2 fill");
      end
      idle();
      chk("R2", "count stays at depth", 32'(entry_count), DEP);
      tick("R7 full hold");
      chk("R7", "fill holds while full", 32'(fill_flag), 1);
      dma_push_done = 1;
      tick("R7 dma clear");
      idle();
      chk("R7", "fill cleared by dma", 32'(fill_flag), 0);
      tick("R7 stays clear");
      chk("R7", "fill stays clear while full", 32'(fill_flag), 0);

      // R4 / R3: drain in order, then an extra load on empty
      for (int i = 0; i < 5; i++) begin
         sh_load = 1;
         tick("R3 drain");
      end
      idle();
      chk("R3", "ptr wrapped after drain", 32'(next_ptr), 0);
      chk("R6", "fill set when room", 32'(fill_flag), 1);

      // R6 / R7: software clear while not full gives a one-cycle drop
      flag_clr = 3'b001;
      tick("R7 sw clear");
      idle();
      chk("R7", "sw clear drops fill", 32'(fill_flag), 0);
      tick("R6 refill");
      chk("R6", "fill back when room", 32'(fill_flag), 1);

      // R5: simultaneous push and load
      push_valid = 1; push_data = 32'h5555_0001; tick("R5 seed");
      push_data = 32'h5555_0002; sh_load = 1; tick("R5 both");
      chk("R5", "count unchanged", 32'(entry_count), 1);
      idle();

      // R8: flush beats a concurrent push and load
      push_valid = 1; push_data = 32'h8888_0000; tick("R8 seed");
      flush_req = 1; push_valid = 1; sh_load = 1; tick("R8 flush");
      idle();
      chk("R8", "count zero", 32'(entry_count), 0);
      chk("R8", "ptr zero", 32'(next_ptr), 0);

      // R9 / R10: set, clear, set-wins, gating by mode and emptiness
      sh_eot = 1; flag_clr = 3'b010; tick("R9 set wins");
      sh_eot = 0; tick("R9 w1c");
      flag_clr = 3'b000; slave_mode = 0; slv_start = 1; tick("R10 master mode");
      chk("R10", "no uf in master mode", 32'(uf_flag), 0);
      slave_mode = 1; tick("R10 slave empty");
      chk("R10", "uf on empty start", 32'(uf_flag), 1);
      slv_start = 0; flag_clr = 3'b100; tick("R10 w1c");
      flag_clr = 3'b000; push_valid = 1; push_data = 32'h1; tick("R10 seed");
      push_valid = 0; slv_start = 1; tick("R10 nonempty");
      chk("R10", "no uf when queued", 32'(uf_flag), 0);
      idle();
      fill_to_dma = 0; tick("R11 irq route");
      flush_req = 1; tick("R8 clean");
      idle();

      // pseudo-random sweep in push-heavy, load-heavy and balanced phases
      for (int i = 0; i < 6000; i++) begin
         int phase;
         phase = (i / 400) % 3;
         rng = next_rng(rng);
         push_valid = (phase == 0) ? (rng[0] | rng[1]) :
                      (phase == 1) ? (rng[0] & rng[1]) : rng[0];
         sh_load    = (phase == 0) ? (rng[2] & rng[3]) :
                      (phase == 1) ? (rng[2] | rng[3]) : rng[2];
         flush_req     = (rng[8:4] == 5'd0);
         flag_clr      = rng[11:9] & {3{rng[12] & rng[13]}};
         dma_push_done = rng[14] & rng[15];
         sh_eot        = rng[16] & rng[17];
         slv_start     = rng[18];
         slave_mode    = rng[19] | rng[20];
         fill_req_en   = rng[21] | rng[25];
         fill_to_dma   = rng[22];
         done_irq_en   = rng[23] | rng[26];
         uf_irq_en     = rng[24] | rng[27];
         rng = next_rng(rng);
         push_data = rng;
         tick("R2 R3 R6 R9 R10 sweep");
      end
      idle();
      finish_run();
   end

endmodule